// File: doc/BRIEF.md
# Bus Data Beat Sequencer

This block turns one memory transfer request into the data beats of a synchronous data bus. A request is either a single-beat transfer of 1, 2, 3, 4 or 8 bytes at any byte address, or a burst that moves one whole 32-byte cache line. For every beat the block drives a valid strobe, the byte-lane enables, the beat index, the address of that beat and a flag on the final beat. A completion pulse follows each transfer.

A mode input selects the data bus width. In wide mode the bus has eight byte lanes. In narrow mode only lanes 3:0 carry data. The two modes share one sequencer. They differ only in which lanes are enabled and in how many beats a transfer takes. A single transfer that does not fit inside the bus width is refused with an error pulse, and no beats are driven for it. A new request can be taken while the block is idle, or in the same cycle as the final beat of the transfer in progress, so that beats can run back to back.

All inputs are sampled, and all registered outputs change, on the rising clock edge.

Top module: `beat_sequencer`

## Requirements
- R1: Legal single-beat sizes are 1, 2, 3, 4 and 8 bytes. Any other value of `req_size` on a non-burst request gives an error pulse and no beats.
- R2: In wide mode (`bus_wide`=1) a single transfer gives one beat at `req_addr`. Lane i is enabled for byte offset i, so the lanes are `size` ones shifted left by `addr[2:0]`. If `addr[2:0]+size > 8` the request is refused with an error.
- R3: In narrow mode (`bus_wide`=0) only lanes 3:0 are ever enabled. A single transfer of 1 to 4 bytes gives one beat whose lanes are shifted by `addr[1:0]`, and it is refused if `addr[1:0]+size > 4`. An 8-byte transfer must be 8-byte aligned. It gives two beats with lanes 0x0F at `addr` and `addr+4`; when it is not aligned, it is refused.
- R4: A burst (`req_burst`=1) is never refused. It starts at `req_addr` rounded down to a multiple of 32 and climbs in address. In wide mode it takes 4 beats, 8 bytes apart, with lanes 0xFF. In narrow mode it takes 8 beats, 4 bytes apart, with lanes 0x0F.
- R5: `beat_idx` counts 0,1,2,... across the beats of a transfer. `beat_last` is high only on the final beat, exactly once per transfer.
- R6: `done` is high for one cycle, in the cycle right after the final beat.
- R7: `req_ready` is high while idle and during a final beat, and low during any other beat. A request presented while `req_ready` is low is ignored and does not change the beats in progress.
- R8: `req_err` is high for one cycle, in the cycle after a refused request is accepted. No beat is driven for that request.
- R9: After reset, `beat_valid`, `beat_last`, `done` and `req_err` are low, and `req_ready` is high.
- R10: The first beat is driven in the cycle after acceptance. The beats of a transfer come on consecutive cycles, and a request taken during a final beat starts its first beat in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wide | input | 1 | 1 = eight-lane bus, 0 = four-lane bus |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 4 | Byte count of a single transfer |
| req_burst | input | 1 | 1 = whole-line burst, size ignored |
| req_ready | output | 1 | Request is taken this cycle if valid |
| beat_valid | output | 1 | A data beat is on the bus |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_lanes | output | 8 | Byte-lane enables of the current beat |
| beat_idx | output | IDX_W | Index of the beat within the transfer |
| beat_last | output | 1 | Final beat of the transfer |
| done | output | 1 | Transfer finished (cycle after final beat) |
| req_err | output | 1 | Previous accepted request was refused |

## Verification
Two events can land in the same cycle. The completion pulse of one transfer can coincide with the first beat of the next, and it can also coincide with the error pulse of a refused request. The bench provokes both cases by holding a request valid through a running transfer. It then checks that `req_ready` stays low until the final beat and that the beats in progress are unchanged. In the cycle after the final beat it checks that `done`, the new beat (address, lanes, index 0) or the error pulse all appear together. It also checks that the first request was not taken early.

// File: rtl/beat_seq_pkg.sv
package beat_seq_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  function automatic logic size_legal(input logic [3:0] sz);
    return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd3) ||
           (sz == 4'd4) || (sz == 4'd8);
  endfunction

  function automatic logic [7:0] size_mask(input logic [3:0] sz);
    logic [7:0] m;
    m = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < sz) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic fits_lanes(input logic [3:0] off,
                                      input logic [3:0] sz,
                                      input logic [3:0] width);
    return (5'(off) + 5'(sz)) <= 5'(width);
  endfunction

endpackage

// File: rtl/beat_req_decode.sv
module beat_req_decode
  import beat_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int IDX_W      = 3
) (
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  input  logic              burst,
  output logic              err,
  output logic [7:0]        lanes,
  output logic [IDX_W-1:0]  last_idx,
  output logic [1:0]        step_lg,
  output logic [ADDR_W-1:0] start
);

  localparam int WIDE_BEATS   = LINE_BYTES / 8;
  localparam int NARROW_BEATS = LINE_BYTES / 4;
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [3:0] wide_off;
  logic [3:0] narrow_off;
  logic [7:0] mask;
  logic       sz_ok;

  assign wide_off   = {1'b0, addr[2:0]};
  assign narrow_off = {2'b00, addr[1:0]};
  assign mask       = size_mask(size);
  assign sz_ok      = size_legal(size);

  always_comb begin
    err      = 1'b0;
    lanes    = 8'h00;
    last_idx = '0;
    step_lg  = 2'd3;
    start    = addr;
    if (burst) begin
      start    = addr & ~LINE_MASK;
      lanes    = wide ? 8'hFF : 8'h0F;
      step_lg  = wide ? 2'd3 : 2'd2;
      last_idx = wide ? IDX_W'(WIDE_BEATS - 1) : IDX_W'(NARROW_BEATS - 1);
    end else if (!sz_ok) begin
      err = 1'b1;
    end else if (wide) begin
      if (fits_lanes(wide_off, size, 4'd8)) lanes = mask << wide_off;
      else err = 1'b1;
    end else if (size == 4'd8) begin
      step_lg = 2'd2;
      if (addr[2:0] == 3'd0) begin
        lanes    = 8'h0F;
        last_idx = IDX_W'(1);
      end else begin
        err = 1'b1;
      end
    end else begin
      step_lg = 2'd2;
      if (fits_lanes(narrow_off, size, 4'd4)) lanes = mask << narrow_off;
      else err = 1'b1;
    end
  end

endmodule

// File: rtl/beat_track.sv
module beat_track
  import beat_seq_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_last,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);

  seq_state_e       state;
  logic [IDX_W-1:0] last_q;

  assign active  = (state == ST_RUN);
  assign at_last = active && (idx == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      last_q <= '0;
    end else if (load) begin
      state  <= ST_RUN;
      idx    <= '0;
      last_q <= load_last;
    end else if (at_last) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else if (active) begin
      idx <= idx + IDX_W'(1);
    end
  end

  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx <= last_q));

  assert_step_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !at_last) |=> (active && idx == $past(idx) + IDX_W'(1)));

endmodule

// File: rtl/beat_addr_gen.sv
module beat_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wide,
  input  logic [ADDR_W-1:0] start,
  input  logic [1:0]        step_lg,
  input  logic [7:0]        lanes,
  input  logic              active,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr_out,
  output logic [7:0]        lanes_out
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic [7:0]        lanes_q;
  logic              wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      step_q  <= 2'd3;
      lanes_q <= 8'h00;
      wide_q  <= 1'b1;
    end else if (load) begin
      base_q  <= start;
      step_q  <= step_lg;
      lanes_q <= lanes;
      wide_q  <= wide;
    end
  end

  assign addr_out  = active ? (base_q + (ADDR_W'(idx) << step_q)) : '0;
  assign lanes_out = active ? lanes_q : 8'h00;

  assert_narrow_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !wide_q) |-> (lanes_out[7:4] == 4'h0));

  assert_some_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (lanes_out != 8'h00));

endmodule

// File: rtl/beat_sequencer.sv
module beat_sequencer
  import beat_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W     = $clog2(LINE_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wide,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic              req_burst,
  output logic              req_ready,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [7:0]        beat_lanes,
  output logic [IDX_W-1:0]  beat_idx,
  output logic              beat_last,
  output logic              done,
  output logic              req_err
);

  logic              dec_err;
  logic [7:0]        dec_lanes;
  logic [IDX_W-1:0]  dec_last;
  logic [1:0]        dec_step;
  logic [ADDR_W-1:0] dec_start;
  logic              accept_fire;
  logic              load_fire;
  logic              active;
  logic              at_last;

  beat_req_decode #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .IDX_W(IDX_W)) u_dec (
    .wide     (bus_wide),
    .addr     (req_addr),
    .size     (req_size),
    .burst    (req_burst),
    .err      (dec_err),
    .lanes    (dec_lanes),
    .last_idx (dec_last),
    .step_lg  (dec_step),
    .start    (dec_start)
  );

  assign req_ready   = !active || at_last;
  assign accept_fire = req_valid && req_ready;
  assign load_fire   = accept_fire && !dec_err;

  beat_track #(.IDX_W(IDX_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_fire),
    .load_last (dec_last),
    .active    (active),
    .idx       (beat_idx),
    .at_last   (at_last)
  );

  beat_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_fire),
    .wide      (bus_wide),
    .start     (dec_start),
    .step_lg   (dec_step),
    .lanes     (dec_lanes),
    .active    (active),
    .idx       (beat_idx),
    .addr_out  (beat_addr),
    .lanes_out (beat_lanes)
  );

  assign beat_valid = active;
  assign beat_last  = at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      req_err <= 1'b0;
    end else begin
      done    <= at_last;
      req_err <= accept_fire && dec_err;
    end
  end

  assert_last_in_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(beat_last));

  assert_ready_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |-> !req_ready);

  assert_err_from_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> ($past(accept_fire) && !beat_valid));

  assert_first_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (beat_valid && beat_idx == '0));

endmodule

// File: tb/beat_sequencer_test.sv
module beat_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wide = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic        req_burst = 1'b0;
  logic        req_ready, beat_valid, beat_last, done, req_err;
  logic [31:0] beat_addr;
  logic [7:0]  beat_lanes;
  logic [2:0]  beat_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  beat_sequencer uut (
    .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_burst(req_burst),
    .req_ready(req_ready), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_lanes(beat_lanes), .beat_idx(beat_idx), .beat_last(beat_last),
    .done(done), .req_err(req_err)
  );

  typedef struct packed {
    logic        wide;
    logic        burst;
    logic [3:0]  size;
    logic [31:0] addr;
    logic        err;
    logic [3:0]  nbeats;
    logic [31:0] base;
    logic [3:0]  step;
    logic [7:0]  lanes;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 4'd1, 32'h1003, 1'b0, 4'd1, 32'h1003, 4'd8, 8'h08, 4'd2}, // R2
    '{1'b1, 1'b0, 4'd2, 32'h1006, 1'b0, 4'd1, 32'h1006, 4'd8, 8'hC0, 4'd2},
    '{1'b1, 1'b0, 4'd3, 32'h1005, 1'b0, 4'd1, 32'h1005, 4'd8, 8'hE0, 4'd2},
    '{1'b1, 1'b0, 4'd4, 32'h1004, 1'b0, 4'd1, 32'h1004, 4'd8, 8'hF0, 4'd2},
    '{1'b1, 1'b0, 4'd8, 32'h1000, 1'b0, 4'd1, 32'h1000, 4'd8, 8'hFF, 4'd2},
    '{1'b1, 1'b0, 4'd3, 32'h1006, 1'b1, 4'd0, 32'h0,    4'd0, 8'h00, 4'd2},
    '{1'b1, 1'b0, 4'd8, 32'h1004, 1'b1, 4'd0, 32'h0,    4'd0, 8'h00, 4'd2},
    '{1'b1, 1'b1, 4'd0, 32'h1234, 1'b0, 4'd4, 32'h1220, 4'd8, 8'hFF, 4'd4}, // R4
    '{1'b1, 1'b0, 4'd5, 32'h1000, 1'b1, 4'd0, 32'h0,    4'd0, 8'h00, 4'd1}, // R1
    '{1'b0, 1'b0, 4'd1, 32'h1003, 1'b0, 4'd1, 32'h1003, 4'd4, 8'h08, 4'd3}, // R3
    '{1'b0, 1'b0, 4'd3, 32'h1001, 1'b0, 4'd1, 32'h1001, 4'd4, 8'h0E, 4'd3},
    '{1'b0, 1'b0, 4'd2, 32'h1003, 1'b1, 4'd0, 32'h0,    4'd0, 8'h00, 4'd3},
    '{1'b0, 1'b0, 4'd8, 32'h1008, 1'b0, 4'd2, 32'h1008, 4'd4, 8'h0F, 4'd3},
    '{1'b0, 1'b0, 4'd8, 32'h100C, 1'b1, 4'd0, 32'h0,    4'd0, 8'h00, 4'd3},
    '{1'b0, 1'b1, 4'd3, 32'h1234, 1'b0, 4'd8, 32'h1220, 4'd4, 8'h0F, 4'd4},
    '{1'b0, 1'b0, 4'd4, 32'h1004, 1'b0, 4'd1, 32'h1004, 4'd4, 8'h0F, 4'd3},
    '{1'b0, 1'b0, 4'd0, 32'h1000, 1'b1, 4'd0, 32'h0,    4'd0, 8'h00, 4'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic present(input logic w, input logic b, input logic [3:0] s, input logic [31:0] a);
    bus_wide  = w;
    req_burst = b;
    req_size  = s;
    req_addr  = a;
    req_valid = 1'b1;
  endtask

  task automatic run_vec(input vec_t v);
    string t;
    t = $sformatf("R%0d vec addr=%0h", v.req, v.addr);
    @(negedge clk);
    present(v.wide, v.burst, v.size, v.addr);
    chk(req_ready === 1'b1, {t, " ready idle R7"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err === v.err, {t, " err R8"}, 64'(req_err), 64'(v.err));
    if (v.err) begin
      chk(beat_valid === 1'b0, {t, " no beat on err R8"}, 64'(beat_valid), 64'd0);
    end else begin
      for (int i = 0; i < int'(v.nbeats); i++) begin
        if (i > 0) @(negedge clk);
        chk(beat_valid === 1'b1, {t, " valid R10"}, 64'(beat_valid), 64'd1);
        chk(beat_addr === v.base + 32'(i) * 32'(v.step), {t, " addr R4"},
            64'(beat_addr), 64'(v.base + 32'(i) * 32'(v.step)));
        chk(beat_lanes === v.lanes, {t, " lanes"}, 64'(beat_lanes), 64'(v.lanes));
        chk(beat_idx === 3'(i), {t, " idx R5"}, 64'(beat_idx), 64'(i));
        chk(beat_last === (i == int'(v.nbeats) - 1), {t, " last R5"},
            64'(beat_last), 64'(i == int'(v.nbeats) - 1));
      end
      @(negedge clk);
      chk(done === 1'b1, {t, " done R6"}, 64'(done), 64'd1);
      chk(beat_valid === 1'b0, {t, " idle after"}, 64'(beat_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(beat_valid === 1'b0 && beat_last === 1'b0, "R9 reset beats", 64'(beat_valid), 64'd0);
    chk(done === 1'b0 && req_err === 1'b0, "R9 reset pulses", 64'({done, req_err}), 64'd0);
    chk(req_ready === 1'b1, "R9 reset ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R7 / R10 / R6: back-to-back, request held during a wide burst
    @(negedge clk);
    present(1'b1, 1'b1, 4'd0, 32'h2008);
    @(negedge clk);
    present(1'b1, 1'b0, 4'd1, 32'h3001);
    chk(beat_addr === 32'h2000, "R4 b2b beat0", 64'(beat_addr), 64'h2000);
    chk(req_ready === 1'b0, "R7 busy not ready", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(beat_addr === 32'h2008 && beat_idx === 3'd1, "R7 held req ignored beat1",
        64'(beat_addr), 64'h2008);
    @(negedge clk);
    chk(beat_addr === 32'h2010 && beat_lanes === 8'hFF, "R7 held req ignored beat2",
        64'(beat_addr), 64'h2010);
    @(negedge clk);
    chk(beat_last === 1'b1 && req_ready === 1'b1, "R7 ready on last beat",
        64'({beat_last, req_ready}), 64'h3);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done === 1'b1, "R6 done with next beat", 64'(done), 64'd1);
    chk(beat_valid === 1'b1 && beat_idx === 3'd0 && beat_addr === 32'h3001,
        "R10 back-to-back first beat", 64'(beat_addr), 64'h3001);
    chk(beat_lanes === 8'h02 && beat_last === 1'b1, "R2 b2b lanes",
        64'(beat_lanes), 64'h02);
    @(negedge clk);
    chk(done === 1'b1 && beat_valid === 1'b0, "R6 done after single",
        64'({done, beat_valid}), 64'h2);

    // R8 with R6: refused request taken on the last beat of a split transfer
    @(negedge clk);
    present(1'b0, 1'b0, 4'd8, 32'h4000);
    @(negedge clk);
    present(1'b1, 1'b0, 4'd6, 32'h5000);
    chk(req_ready === 1'b0 && beat_addr === 32'h4000, "R3 split beat0",
        64'(beat_addr), 64'h4000);
    @(negedge clk);
    chk(beat_addr === 32'h4004 && beat_last === 1'b1, "R3 split beat1",
        64'(beat_addr), 64'h4004);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done === 1'b1 && req_err === 1'b1, "R8 err with done",
        64'({done, req_err}), 64'h3);
    chk(beat_valid === 1'b0, "R1 refused size no beat", 64'(beat_valid), 64'd0);
    @(negedge clk);
    chk(req_err === 1'b0 && done === 1'b0, "R8 err single pulse",
        64'({done, req_err}), 64'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule